// File: doc/BRIEF.md
# Byte-Wide Boot Loader

This block fills on-chip program memory from a slow external memory that is one byte wide. When the chip-level reset is released it begins on its own: it drives a byte address and a read strobe to the external device and stretches every access by a fixed number of wait states, so that memories much slower than the core clock can be used. Three consecutive bytes are gathered into one 24-bit program word, least significant byte first. Each finished word is written into program memory, at addresses that count up from zero.

The external device can hold several program images. A page-select input, sampled while reset is held, chooses which image is loaded. The image's base byte address is the page number times 0x2000, so the page value is the top field of the external address. The core is kept in reset during loading. A one-cycle done pulse follows the last write, and the core is then released. After that the loader stays quiet until the next reset.

Each byte access holds the strobe for 1 + WAIT_STATES cycles. The strobe then drops for one cycle, which is either a gap or the program-memory write cycle. A word therefore takes 15 cycles with the default three wait states.

Top module: `boot_loader`

## Requirements
- R1: While `rst` is high, `ext_rd`, `pm_we` and `boot_done` are 0 and `core_hold` is 1. `page_sel` is sampled on every clock edge that has `rst` high.
- R2: Loading starts with no other input. In the cycle after the first clock edge with `rst` low, `ext_rd` is 1 and `ext_addr` holds the base address of the selected image.
- R3: Every read strobe stays high for exactly 1+WAIT_STATES cycles (4 by default), and `ext_addr` is stable for that whole time. `ext_data` is taken only on the last cycle of the strobe. Its value on the other cycles has no effect.
- R4: Byte addresses go up by one from one strobe to the next. Three consecutive bytes form one program word: the first byte goes to bits 7:0, the second to 15:8 and the third to 23:16.
- R5: Each word is written with a single-cycle `pm_we` pulse. This pulse comes in the cycle after its third byte is taken, and `ext_rd` is low during it. Writes go to `pm_addr` 0, 1, 2 … LOAD_WORDS-1 in that order, one write per address. `ext_rd` is low for one cycle after the first and second byte of each word.
- R6: The image base address is `page_sel`×0x2000, so `ext_addr[15:13]` carries the sampled page and `ext_addr[12:0]` the byte offset. A change on `page_sel` after reset is released has no effect on the load.
- R7: `boot_done` is high for exactly one cycle: the cycle after the final write. With the defaults, it is seen 15×2048+1 clock edges after the first edge with `rst` low.
- R8: `core_hold` stays 1 from reset through the cycle in which `boot_done` is high, and is 0 from then on. While `core_hold` is 0, no further `ext_rd` or `pm_we` occurs.
- R9: A reset asserted in the middle of a load stops it. After release, the load restarts at word 0 from the base of the newly sampled page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release starts a load |
| page_sel | input | 3 | Image select, sampled while reset is high |
| ext_addr | output | 16 | External byte address: page in bits 15:13, offset in bits 12:0 |
| ext_rd | output | 1 | External read strobe, active high |
| ext_data | input | 8 | Byte returned by the external memory |
| pm_we | output | 1 | Program memory write enable, one cycle per word |
| pm_addr | output | 11 | Program memory word address |
| pm_wdata | output | 24 | Packed program word |
| boot_done | output | 1 | One-cycle pulse after the final word is written |
| core_hold | output | 1 | Keeps the core in reset while high |

## Verification
The external memory model returns a byte that depends on the full address, and it returns the inverted byte on every strobe cycle except the last. A capture taken one cycle early or late therefore shows up as a wrong word, and a swapped byte order or a slipped address is also visible in the image comparison. Full loads from page 0 and page 7 test both extremes of the page field. A third load changes `page_sel` after reset is released, which must leave its image unaltered. A reset asserted in the middle of a load, with a new page, checks that the word count and the byte offset both restart at zero.

// File: rtl/boot_pkg.sv
package boot_pkg;

    // Default geometry of the loader
    localparam int BOOT_BYTE_W = 8;
    localparam int BOOT_WORD_W = 24;
    localparam int BOOT_PAGE_W = 3;
    localparam int BOOT_SPAN_W = 13;   // bytes per image region = 2**SPAN_W
    localparam int BOOT_WAITS  = 3;
    localparam int BOOT_WORDS  = 2048;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_GAP   = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4,
        ST_RUN   = 3'd5
    } boot_state_e;

    typedef struct packed {
        logic rd;
        logic we;
        logic done;
        logic hold;
    } boot_ctrl_t;

    // Width of a counter that must reach maxval (never below one bit)
    function automatic int cnt_width(input int maxval);
        return (maxval < 1) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
    parameter int WAITS = boot_pkg::BOOT_WAITS
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic last
);
    localparam int CW = boot_pkg::cnt_width(WAITS);
    localparam logic [CW-1:0] CNT_END = CW'(WAITS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (cnt == CNT_END) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Final cycle of the stretched access: the byte is taken here
    assign last = active && (cnt == CNT_END);

endmodule

// File: rtl/boot_word_packer.sv
module boot_word_packer #(
    parameter int BYTE_W = boot_pkg::BOOT_BYTE_W,
    parameter int WORD_W = boot_pkg::BOOT_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [WORD_W-1:0] word,
    output logic              complete
);
    localparam int BYTES = WORD_W / BYTE_W;
    localparam int SW    = boot_pkg::cnt_width(BYTES - 1);
    localparam logic [SW-1:0] SLOT_LAST = SW'(BYTES - 1);

    logic [SW-1:0]     slot;
    logic [WORD_W-1:0] acc;

    // New byte enters at the top; after BYTES captures the first byte sits at the bottom
    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
            acc  <= '0;
        end else if (capture) begin
            acc  <= {byte_in, acc[WORD_W-1:BYTE_W]};
            slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
        end
    end

    assign complete = capture && (slot == SLOT_LAST);
    assign word     = acc;

endmodule

// File: rtl/boot_addr_gen.sv
module boot_addr_gen #(
    parameter int PAGE_W = boot_pkg::BOOT_PAGE_W,
    parameter int SPAN_W = boot_pkg::BOOT_SPAN_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PAGE_W-1:0]        page_sel,
    input  logic                     step,
    output logic [PAGE_W+SPAN_W-1:0] ext_addr
);
    logic [PAGE_W-1:0] page_q;
    logic [SPAN_W-1:0] offset;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= page_sel;
            offset <= '0;
        end else if (step) begin
            offset <= offset + 1'b1;
        end
    end

    // base = page * 2**SPAN_W, formed by placement rather than an adder
    assign ext_addr = {page_q, offset};

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer #(
    parameter int WORDS = boot_pkg::BOOT_WORDS,
    parameter int AW    = boot_pkg::cnt_width(WORDS - 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  capture,
    input  logic                  complete,
    output boot_pkg::boot_ctrl_t  ctrl,
    output logic [AW-1:0]         word_idx
);
    import boot_pkg::*;

    localparam logic [AW-1:0] IDX_LAST = AW'(WORDS - 1);

    boot_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = ST_READ;
            ST_READ:  if (capture) state_nx = complete ? ST_WRITE : ST_GAP;
            ST_GAP:   state_nx = ST_READ;
            ST_WRITE: state_nx = (word_idx == IDX_LAST) ? ST_DONE : ST_READ;
            ST_DONE:  state_nx = ST_RUN;
            ST_RUN:   state_nx = ST_RUN;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            word_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_WRITE && word_idx != IDX_LAST) begin
                word_idx <= word_idx + 1'b1;
            end
        end
    end

    always_comb begin
        ctrl.rd   = (state == ST_READ);
        ctrl.we   = (state == ST_WRITE);
        ctrl.done = (state == ST_DONE);
        ctrl.hold = (state != ST_RUN);
    end

endmodule

// File: rtl/boot_loader.sv
module boot_loader #(
    parameter int WAIT_STATES = boot_pkg::BOOT_WAITS,
    parameter int LOAD_WORDS  = boot_pkg::BOOT_WORDS,
    parameter int PAGE_W      = boot_pkg::BOOT_PAGE_W,
    parameter int SPAN_W      = boot_pkg::BOOT_SPAN_W,
    parameter int BYTE_W      = boot_pkg::BOOT_BYTE_W,
    parameter int WORD_W      = boot_pkg::BOOT_WORD_W,
    localparam int EXT_AW     = PAGE_W + SPAN_W,
    localparam int PM_AW      = boot_pkg::cnt_width(LOAD_WORDS - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PAGE_W-1:0] page_sel,
    output logic [EXT_AW-1:0] ext_addr,
    output logic              ext_rd,
    input  logic [BYTE_W-1:0] ext_data,
    output logic              pm_we,
    output logic [PM_AW-1:0]  pm_addr,
    output logic [WORD_W-1:0] pm_wdata,
    output logic              boot_done,
    output logic              core_hold
);
    boot_pkg::boot_ctrl_t ctrl;
    logic capture;
    logic complete;

    boot_sequencer #(.WORDS(LOAD_WORDS), .AW(PM_AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .complete (complete),
        .ctrl     (ctrl),
        .word_idx (pm_addr)
    );

    boot_wait_timer #(.WAITS(WAIT_STATES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (ctrl.rd),
        .last   (capture)
    );

    boot_addr_gen #(.PAGE_W(PAGE_W), .SPAN_W(SPAN_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .page_sel (page_sel),
        .step     (capture),
        .ext_addr (ext_addr)
    );

    boot_word_packer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_pack (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .byte_in  (ext_data),
        .word     (pm_wdata),
        .complete (complete)
    );

    assign ext_rd    = ctrl.rd;
    assign pm_we     = ctrl.we;
    assign boot_done = ctrl.done;
    assign core_hold = ctrl.hold;

endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk #(
    parameter int WAIT_STATES = 3,
    parameter int LOAD_WORDS  = 2048,
    parameter int PAGE_W      = 3,
    parameter int SPAN_W      = 13,
    parameter int PM_AW       = 11
) (
    input logic                     clk,
    input logic                     rst,
    input logic [PAGE_W-1:0]        page_sel,
    input logic [PAGE_W+SPAN_W-1:0] ext_addr,
    input logic                     ext_rd,
    input logic                     pm_we,
    input logic [PM_AW-1:0]         pm_addr,
    input logic                     boot_done,
    input logic                     core_hold
);
    localparam int NREAD = WAIT_STATES + 1;
    localparam logic [PM_AW-1:0] ADDR_LAST = PM_AW'(LOAD_WORDS - 1);

    logic [7:0]        run_cnt;
    logic [PM_AW:0]    wr_cnt;
    logic [PAGE_W-1:0] page_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt   <= '0;
            wr_cnt    <= '0;
            page_seen <= page_sel;
        end else begin
            run_cnt <= ext_rd ? ((run_cnt == 8'hFF) ? run_cnt : run_cnt + 8'd1) : 8'd0;
            if (pm_we) wr_cnt <= wr_cnt + 1'b1;
        end
    end

    assert_strobe_len_R3: assert property (@(posedge clk) disable iff (rst)
        (!ext_rd && $past(ext_rd)) |-> (run_cnt == 8'(NREAD)));

    assert_strobe_bound_R3: assert property (@(posedge clk) disable iff (rst)
        ext_rd |-> (run_cnt < 8'(NREAD)));

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (ext_rd && $past(ext_rd)) |-> $stable(ext_addr));

    assert_page_field_R6: assert property (@(posedge clk) disable iff (rst)
        ext_rd |-> (ext_addr[PAGE_W+SPAN_W-1:SPAN_W] == page_seen));

    assert_write_order_R5: assert property (@(posedge clk) disable iff (rst)
        pm_we |-> (pm_addr == wr_cnt[PM_AW-1:0]));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
        !(pm_we && ext_rd));

    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> ($past(pm_we) && $past(pm_addr) == ADDR_LAST));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> (!boot_done && !core_hold));

    assert_quiet_after_R8: assert property (@(posedge clk) disable iff (rst)
        !core_hold |-> (!ext_rd && !pm_we && !boot_done));

    assert_hold_stays_R8: assert property (@(posedge clk) disable iff (rst)
        !core_hold |=> !core_hold);

endmodule

bind boot_loader boot_loader_chk #(
    .WAIT_STATES (WAIT_STATES),
    .LOAD_WORDS  (LOAD_WORDS),
    .PAGE_W      (PAGE_W),
    .SPAN_W      (SPAN_W),
    .PM_AW       (PM_AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .page_sel  (page_sel),
    .ext_addr  (ext_addr),
    .ext_rd    (ext_rd),
    .pm_we     (pm_we),
    .pm_addr   (pm_addr),
    .boot_done (boot_done),
    .core_hold (core_hold)
);

// File: tb/boot_loader_test.sv
`timescale 1ns/1ps
module boot_loader_test;

    localparam int WORDS   = 2048;
    localparam int NREAD   = 4;
    localparam int PER_WORD = 15;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  page_sel = 3'd0;
    logic [15:0] ext_addr;
    logic        ext_rd;
    logic [7:0]  ext_data;
    logic        pm_we;
    logic [10:0] pm_addr;
    logic [23:0] pm_wdata;
    logic        boot_done;
    logic        core_hold;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    boot_loader uut (
        .clk       (clk),
        .rst       (rst),
        .page_sel  (page_sel),
        .ext_addr  (ext_addr),
        .ext_rd    (ext_rd),
        .ext_data  (ext_data),
        .pm_we     (pm_we),
        .pm_addr   (pm_addr),
        .pm_wdata  (pm_wdata),
        .boot_done (boot_done),
        .core_hold (core_hold)
    );

    // ---------------- external memory model ----------------
    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        logic [7:0] hi;
        hi = a[15:8];
        return (a[7:0] + hi * 8'd37) ^ 8'h5A;
    endfunction

    int rd_age = 0;
    // correct byte only on the final strobe cycle, inverted otherwise
    assign ext_data = (ext_rd && rd_age == NREAD - 1) ? rom_byte(ext_addr) : ~rom_byte(ext_addr);

    // ---------------- monitors ----------------
    logic [23:0] pm_model [WORDS];
    int          cyc = 0;
    int          wr_cnt = 0;
    int          order_err = 0;
    int          len_err = 0;
    int          step_err = 0;
    int          stab_err = 0;
    int          post_act = 0;
    bit          post_flag = 1'b0;
    bit          have_prev = 1'b0;
    logic [15:0] prev_addr = '0;
    int          total_cyc = 0;

    always @(posedge clk) begin
        total_cyc <= total_cyc + 1;
        if (rst) begin
            cyc <= 0; wr_cnt <= 0; order_err <= 0; len_err <= 0;
            step_err <= 0; stab_err <= 0; have_prev <= 1'b0; rd_age <= 0;
        end else begin
            cyc <= cyc + 1;
            if (pm_we) begin
                pm_model[pm_addr] <= pm_wdata;
                if (int'(pm_addr) != wr_cnt) order_err <= order_err + 1;
                wr_cnt <= wr_cnt + 1;
            end
            if (ext_rd) begin
                if (rd_age == 0) begin
                    if (have_prev && ext_addr != prev_addr + 16'd1) step_err <= step_err + 1;
                    prev_addr <= ext_addr;
                    have_prev <= 1'b1;
                end else if (ext_addr != prev_addr) begin
                    stab_err <= stab_err + 1;
                end
                rd_age <= rd_age + 1;
            end else begin
                if (rd_age != 0 && rd_age != NREAD) len_err <= len_err + 1;
                rd_age <= 0;
            end
            if (post_flag && (ext_rd || pm_we || core_hold)) post_act <= post_act + 1;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic hold_reset(input logic [2:0] pg);
        @(negedge clk);
        rst = 1'b1;
        page_sel = pg;
        post_flag = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_reset_outputs(input string tag);
        chk(ext_rd == 1'b0,    {tag, " R1 ext_rd in reset"},    int'(ext_rd), 0);
        chk(pm_we == 1'b0,     {tag, " R1 pm_we in reset"},     int'(pm_we), 0);
        chk(boot_done == 1'b0, {tag, " R1 boot_done in reset"}, int'(boot_done), 0);
        chk(core_hold == 1'b1, {tag, " R1 core_hold in reset"}, int'(core_hold), 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        hold_reset(3'd0);
        check_reset_outputs("reset");
    endtask

    task automatic t_full_load(input logic [2:0] pg, input bit flip_page);
        int bad;
        int first_bad;
        logic [23:0] exp_w;
        logic [23:0] got_w;
        logic [15:0] a;
        hold_reset(pg);
        check_reset_outputs("load");
        rst = 1'b0;
        @(negedge clk);
        chk(ext_rd == 1'b1, "R2 strobe after release", int'(ext_rd), 1);
        chk(ext_addr == {pg, 13'd0}, "R2 R6 first address", int'(ext_addr), int'({pg, 13'd0}));
        if (flip_page) begin
            repeat (200) @(negedge clk);
            page_sel = ~pg;
        end
        while (!boot_done && cyc < PER_WORD * WORDS + 50) @(negedge clk);
        chk(boot_done == 1'b1, "R7 done reached", int'(boot_done), 1);
        chk(cyc == PER_WORD * WORDS + 1, "R7 done timing", cyc, PER_WORD * WORDS + 1);
        chk(core_hold == 1'b1, "R8 hold during done", int'(core_hold), 1);
        @(negedge clk);
        chk(boot_done == 1'b0, "R7 done one cycle", int'(boot_done), 0);
        chk(core_hold == 1'b0, "R8 core released", int'(core_hold), 0);
        chk(len_err == 0, "R3 strobe length", len_err, 0);
        chk(stab_err == 0, "R3 address stable", stab_err, 0);
        chk(step_err == 0, "R4 address step", step_err, 0);
        chk(order_err == 0, "R5 write order", order_err, 0);
        chk(wr_cnt == WORDS, "R5 write count", wr_cnt, WORDS);
        bad = 0;
        first_bad = -1;
        for (int i = 0; i < WORDS; i++) begin
            a = {pg, 13'(3 * i)};
            exp_w = {rom_byte(a + 16'd2), rom_byte(a + 16'd1), rom_byte(a)};
            got_w = pm_model[i];
            if (got_w != exp_w) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
        end
        if (first_bad >= 0) begin
            a = {pg, 13'(3 * first_bad)};
            exp_w = {rom_byte(a + 16'd2), rom_byte(a + 16'd1), rom_byte(a)};
            chk(1'b0, flip_page ? "R6 page change ignored / R4 image" : "R4 image contents",
                int'(pm_model[first_bad]), int'(exp_w));
        end else begin
            chk(1'b1, "R4 image contents", 0, 0);
        end
        post_flag = 1'b1;
        repeat (40) @(negedge clk);
        chk(post_act == 0, "R8 quiet after release", post_act, 0);
        post_flag = 1'b0;
        post_act = 0;
    endtask

    task automatic t_mid_reset();
        hold_reset(3'd3);
        rst = 1'b0;
        repeat (100) @(negedge clk);
        chk(wr_cnt > 0, "R9 load in progress", wr_cnt, 1);
        hold_reset(3'd2);
        check_reset_outputs("R9 mid-load");
        rst = 1'b0;
        @(negedge clk);
        chk(ext_addr == 16'h4000, "R9 restart address", int'(ext_addr), 16'h4000);
        repeat (PER_WORD + 2) @(negedge clk);
        chk(wr_cnt == 1, "R9 one word after restart", wr_cnt, 1);
        chk(order_err == 0, "R9 restart at word 0", order_err, 0);
        chk(pm_model[0] == {rom_byte(16'h4002), rom_byte(16'h4001), rom_byte(16'h4000)},
            "R9 first word from new page", int'(pm_model[0]),
            int'({rom_byte(16'h4002), rom_byte(16'h4001), rom_byte(16'h4000)}));
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (total_cyc == WD_LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<%0d cycles", total_cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_full_load(3'd0, 1'b0);
        t_full_load(3'd7, 1'b0);
        t_full_load(3'd5, 1'b1);
        t_mid_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule